// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block turns parallel characters into an asynchronous serial stream on a single line that idles high. The host places a character in a one-entry holding register with a write strobe. From there the character moves into a shift register, which sends it as a frame: a low start bit, the data least significant bit first, an optional ninth bit, and a high stop bit. Bit periods are paced by a one-cycle tick pulse that an external baud generator supplies.

Two status outputs show whether the holding register and the shift register are empty. The holding-register-empty flag also drives an interrupt line, which is raised only while its enable input is set. The host can also request a break: thirteen low bit periods followed by one high period. The request is visible as a pending flag that clears by itself once the break has been sent. A global enable gates everything. Dropping it flushes both registers and any pending break.

Top module: `async_char_tx`

## Requirements
- R1: After reset, `tx_line` is 1 and `hold_empty` and `shift_empty` are 1. The line stays 1 whenever the shifter is idle.
- R2: With `wide_mode` 0, a character is sent as 10 bit periods: a 0 start bit, data bits 0 to 7 in that order, and a 1 stop bit. Each period ends on a cycle where `bit_tick` is 1, and the line does not change between ticks.
- R3: With `wide_mode` 1 at the write, the frame has 11 periods. The value of `ninth_bit` at the write is sent between data bit 7 and the stop bit.
- R4: A write that arrives while `tx_enable` is 1 and the holding register is empty clears `hold_empty` on the next cycle. If the shifter is idle, the character moves into it on the following cycle without waiting for a tick: `hold_empty` returns to 1, `shift_empty` goes to 0, and the start bit appears on `tx_line`.
- R5: If the holding register is full when a frame's stop bit ends, the next frame's start bit begins on that same tick, so the shifter never goes idle in between.
- R6: A write is ignored while the holding register is full and no transfer to the shifter takes place in that cycle.
- R7: A write that lands in the same cycle as a transfer from the holding register to the shifter is accepted, and that character is sent after the one being transferred.
- R8: `irq` equals `hold_empty` AND `irq_enable`.
- R9: A `brk_set` pulse while enabled sets `brk_pending` on the next cycle. The break is 13 low periods followed by 1 high period. `brk_pending` clears when that high period ends. A pending break is sent before a character waiting in the holding register.
- R10: While `tx_enable` is 0, the holding register, the shifter and any pending break are cleared on the next cycle, `tx_line` is 1, and writes and break requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_enable | input | 1 | Global transmit enable |
| wide_mode | input | 1 | Selects 9-bit characters; sampled with the write |
| ninth_bit | input | 1 | Ninth data bit; sampled with the write |
| wr_strobe | input | 1 | One-cycle host write strobe |
| wr_data | input | 8 | Character to send |
| brk_set | input | 1 | One-cycle break request |
| bit_tick | input | 1 | One-cycle pulse marking the end of a bit period |
| irq_enable | input | 1 | Interrupt enable for holding-register-empty |
| tx_line | output | 1 | Serial output, idles high |
| hold_empty | output | 1 | Holding register is empty |
| shift_empty | output | 1 | Shift register is idle |
| brk_pending | output | 1 | Break requested and not yet finished |
| irq | output | 1 | Holding-register-empty interrupt |

## Verification
Two events can fall in the same cycle: a host write, and the transfer of the queued character into the shifter on the tick that ends a stop bit. The bench provokes this collision by tracking how many expected serial bits remain. It raises the write strobe exactly on the tick that ends the earlier frame. The collision is judged correct if the recovered serial stream holds all three characters in order, with no gap. A second collision pits a pending break against a character waiting in the holding register. The break must come out first.

// File: rtl/tx_chr_pkg.sv
package tx_chr_pkg;

  // Low periods of a break character; one high period follows.
  localparam int unsigned BRK_LOW_BITS = 13;

  typedef enum logic [1:0] {
    FR_IDLE  = 2'd0,
    FR_CHAR  = 2'd1,
    FR_BREAK = 2'd2
  } frame_kind_e;

  // Number of bit periods in a frame.
  function automatic int unsigned frame_len(input logic is_brk, input logic wide,
                                            input int unsigned data_w);
    if (is_brk) return BRK_LOW_BITS + 1;
    return data_w + 2 + (wide ? 1 : 0);
  endfunction

endpackage

// File: rtl/tx_hold_buf.sv
module tx_hold_buf #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_wide,
  input  logic              wr_ninth,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data_q,
  output logic              wide_q,
  output logic              ninth_q,
  output logic              accept
);

  logic full_q;

  // A write is taken when the slot is free or is being emptied this cycle.
  assign accept = enable & wr_stb & (~full_q | take);
  assign full   = full_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q  <= 1'b0;
      data_q  <= '0;
      wide_q  <= 1'b0;
      ninth_q <= 1'b0;
    end else if (!enable) begin
      full_q <= 1'b0;
    end else if (accept) begin
      full_q  <= 1'b1;
      data_q  <= wr_data;
      wide_q  <= wr_wide;
      ninth_q <= wr_ninth;
    end else if (take) begin
      full_q <= 1'b0;
    end
  end

  AST_FULL_DROPS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    enable && full_q && wr_stb && !take |=> $stable(data_q)); // R6
  AST_TAKE_FREES_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    take && !accept |=> !full_q); // R4
  AST_RACE_REFILLS: assert property (@(posedge clk) disable iff (!rst_n)
    take && accept |=> full_q); // R7

endmodule

// File: rtl/tx_brk_ctl.sv
module tx_brk_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic brk_set,
  input  logic brk_done,
  output logic pending
);

  logic pending_q;
  logic set_now;

  assign set_now = enable & brk_set;
  assign pending = pending_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        pending_q <= 1'b0;
    else if (!enable)  pending_q <= 1'b0;
    else if (set_now)  pending_q <= 1'b1;
    else if (brk_done) pending_q <= 1'b0;
  end

  AST_PENDING_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    brk_done && !set_now |=> !pending_q); // R9
  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    set_now |=> pending_q); // R9

endmodule

// File: rtl/tx_shift_core.sv
module tx_shift_core
  import tx_chr_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              bit_tick,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  input  logic              hold_wide,
  input  logic              hold_ninth,
  input  logic              brk_pending,
  output logic              take_hold,
  output logic              brk_done,
  output logic              busy,
  output logic              tx_line
);

  localparam int unsigned CHAR_MAX = DATA_W + 3;
  localparam int unsigned BRK_LEN  = BRK_LOW_BITS + 1;
  localparam int unsigned SR_W     = (CHAR_MAX > BRK_LEN) ? CHAR_MAX : BRK_LEN;
  localparam int unsigned CNT_W    = $clog2(SR_W + 1);

  function automatic logic [SR_W-1:0] pack_char(input logic [DATA_W-1:0] d,
                                                input logic wide, input logic ninth);
    logic [SR_W-1:0] f;
    f            = '1;
    f[0]         = 1'b0;
    f[DATA_W:1]  = d;
    if (wide) f[DATA_W+1] = ninth;
    return f;
  endfunction

  function automatic logic [SR_W-1:0] pack_break();
    logic [SR_W-1:0] f;
    f                   = '1;
    f[BRK_LOW_BITS-1:0] = '0;
    return f;
  endfunction

  frame_kind_e      kind_q;
  logic [SR_W-1:0]  sr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last_tick;
  logic             slot;
  logic             start_brk;

  assign busy      = (kind_q != FR_IDLE);
  assign last_tick = busy & bit_tick & (cnt_q == CNT_W'(1));
  assign brk_done  = last_tick & (kind_q == FR_BREAK);
  assign slot      = enable & (~busy | last_tick);
  assign start_brk = slot & brk_pending & ~brk_done;
  assign take_hold = slot & hold_full & ~start_brk;
  assign tx_line   = sr_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      kind_q <= FR_IDLE;
      sr_q   <= '1;
      cnt_q  <= '0;
    end else if (start_brk) begin
      kind_q <= FR_BREAK;
      sr_q   <= pack_break();
      cnt_q  <= CNT_W'(frame_len(1'b1, 1'b0, DATA_W));
    end else if (take_hold) begin
      kind_q <= FR_CHAR;
      sr_q   <= pack_char(hold_data, hold_wide, hold_ninth);
      cnt_q  <= CNT_W'(frame_len(1'b0, hold_wide, DATA_W));
    end else if (last_tick) begin
      kind_q <= FR_IDLE;
      sr_q   <= '1;
      cnt_q  <= '0;
    end else if (busy && bit_tick) begin
      sr_q  <= {1'b1, sr_q[SR_W-1:1]};
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx_line); // R1
  AST_LINE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    enable && busy && !bit_tick |=> $stable(tx_line)); // R2
  AST_BRK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    enable && !busy && brk_pending |=> kind_q == FR_BREAK); // R9
  AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    enable && last_tick && hold_full |=> busy); // R5

endmodule

// File: rtl/async_char_tx.sv
module async_char_tx #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_enable,
  input  logic              wide_mode,
  input  logic              ninth_bit,
  input  logic              wr_strobe,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              brk_set,
  input  logic              bit_tick,
  input  logic              irq_enable,
  output logic              tx_line,
  output logic              hold_empty,
  output logic              shift_empty,
  output logic              brk_pending,
  output logic              irq
);

  logic              take_hold;
  logic              brk_done;
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              hold_wide;
  logic              hold_ninth;
  logic              wr_accept;
  logic              shift_busy;

  tx_hold_buf #(.DATA_W(DATA_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (tx_enable),
    .wr_stb   (wr_strobe),
    .wr_data  (wr_data),
    .wr_wide  (wide_mode),
    .wr_ninth (ninth_bit),
    .take     (take_hold),
    .full     (hold_full),
    .data_q   (hold_data),
    .wide_q   (hold_wide),
    .ninth_q  (hold_ninth),
    .accept   (wr_accept)
  );

  tx_brk_ctl u_brk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (tx_enable),
    .brk_set  (brk_set),
    .brk_done (brk_done),
    .pending  (brk_pending)
  );

  tx_shift_core #(.DATA_W(DATA_W)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (tx_enable),
    .bit_tick    (bit_tick),
    .hold_full   (hold_full),
    .hold_data   (hold_data),
    .hold_wide   (hold_wide),
    .hold_ninth  (hold_ninth),
    .brk_pending (brk_pending),
    .take_hold   (take_hold),
    .brk_done    (brk_done),
    .busy        (shift_busy),
    .tx_line     (tx_line)
  );

  assign hold_empty  = ~hold_full;
  assign shift_empty = ~shift_busy;
  assign irq         = hold_empty & irq_enable;

  AST_DISABLE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_enable |=> hold_empty && shift_empty && !brk_pending); // R10
  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> !hold_empty); // R4
  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_enable); // R8

endmodule

// File: tb/test_async_char_tx.sv
`timescale 1ns/1ps
module test_async_char_tx;

  localparam int TICK_DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       tx_enable = 0, wide_mode = 0, ninth_bit = 0, wr_strobe = 0;
  logic       brk_set = 0, bit_tick = 0, irq_enable = 0;
  logic [7:0] wr_data = 0;
  logic       tx_line, hold_empty, shift_empty, brk_pending, irq;

  async_char_tx #(.DATA_W(8)) i_async_char_tx (
    .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .wide_mode(wide_mode),
    .ninth_bit(ninth_bit), .wr_strobe(wr_strobe), .wr_data(wr_data),
    .brk_set(brk_set), .bit_tick(bit_tick), .irq_enable(irq_enable),
    .tx_line(tx_line), .hold_empty(hold_empty), .shift_empty(shift_empty),
    .brk_pending(brk_pending), .irq(irq)
  );

  int    checks = 0, fails = 0;
  bit    finished = 0;
  logic  exp_q[$];
  string tag_q[$];

  // Requests from the sequencer, served by the negedge driver.
  bit         req_wr = 0, req_force = 0, req_race = 0, req_push = 1;
  bit         req_brk = 0, req_dis = 0;
  int         race_len = 0;
  logic [7:0] rq_data = 0;
  logic       rq_wide = 0, rq_ninth = 0;
  string      rq_tag = "R2";
  int         tick_cnt = 0;
  bit         expect_cont = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic push_char(input logic [7:0] d, input logic wide, input logic nin,
                           input string tag);
    exp_q.push_back(1'b0); tag_q.push_back(tag);
    for (int i = 0; i < 8; i++) begin exp_q.push_back(d[i]); tag_q.push_back(tag); end
    if (wide) begin exp_q.push_back(nin); tag_q.push_back(tag); end
    exp_q.push_back(1'b1); tag_q.push_back(tag);
  endtask

  task automatic push_brk();
    for (int i = 0; i < 13; i++) begin exp_q.push_back(1'b0); tag_q.push_back("R9"); end
    exp_q.push_back(1'b1); tag_q.push_back("R9");
  endtask

  // Driver, tick generator and serial monitor in one negedge process.
  always @(negedge clk) begin
    wr_strobe = 1'b0;
    brk_set   = 1'b0;
    bit_tick  = (tick_cnt == TICK_DIV - 1);
    tick_cnt  = (tick_cnt + 1) % TICK_DIV;
    if (expect_cont) begin
      chk("R5", "shifter idle between queued frames", shift_empty, 0);
      expect_cont = 0;
    end
    if (rst_n && bit_tick && !shift_empty) begin
      if (!hold_empty && tx_enable) expect_cont = 1;
      if (exp_q.size() == 0) begin
        chk("R2", "unexpected serial bit", tx_line, 2);
      end else begin
        logic  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, "serial bit", tx_line, e);
      end
    end
    if (req_wr) begin
      bit fire;
      if (req_race) fire = bit_tick && !shift_empty && !hold_empty && exp_q.size() == race_len;
      else          fire = req_force || hold_empty;
      if (fire) begin
        wr_strobe = 1'b1; wr_data = rq_data; wide_mode = rq_wide; ninth_bit = rq_ninth;
        if (req_push) push_char(rq_data, rq_wide, rq_ninth, rq_tag);
        req_wr = 0;
      end
    end
    if (req_brk) begin
      brk_set = 1'b1;
      if (req_push) push_brk();
      req_brk = 0;
    end
    if (req_dis) begin
      tx_enable = 1'b0;
      exp_q.delete(); tag_q.delete();
      expect_cont = 0;
      req_dis = 0;
    end
  end

  task automatic put(input logic [7:0] d, input logic wide, input logic nin, input string tag);
    rq_data = d; rq_wide = wide; rq_ninth = nin; rq_tag = tag;
    req_wr = 1;
    do @(posedge clk); while (req_wr);
    @(negedge clk);
  endtask

  task automatic drain();
    do @(negedge clk); while (exp_q.size() != 0 || !shift_empty || !hold_empty);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog run did not complete actual=1 expected=0");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "line after reset", tx_line, 1);
    chk("R1", "hold_empty after reset", hold_empty, 1);
    chk("R1", "shift_empty after reset", shift_empty, 1);
    chk("R8", "irq with enable low", irq, 0);
    chk("R9", "brk_pending after reset", brk_pending, 0);
    irq_enable = 1'b1;
    @(negedge clk);
    chk("R8", "irq with holding register empty", irq, 1);
    tx_enable = 1'b1;
    repeat (3) @(negedge clk);

    // R4: write into empty holding register with idle shifter.
    put(8'hA5, 0, 0, "R2");
    chk("R4", "hold_empty after write", hold_empty, 0);
    chk("R8", "irq with holding register full", irq, 0);
    chk("R4", "shifter still idle one cycle after write", shift_empty, 1);
    @(negedge clk);
    chk("R4", "hold_empty after transfer", hold_empty, 1);
    chk("R4", "shift_empty after transfer", shift_empty, 0);
    chk("R4", "start bit driven", tx_line, 0);
    drain();

    // R2/R5: all 8-bit values back to back.
    for (int d = 0; d < 256; d++) put(8'(d), 0, 0, "R2");
    drain();

    // R3: all 9-bit combinations.
    for (int d = 0; d < 256; d++)
      for (int n = 0; n < 2; n++) put(8'(d), 1, 1'(n), "R3");
    drain();

    // R6: write while full is dropped.
    put(8'h3C, 0, 0, "R6");
    put(8'hC3, 0, 0, "R6");
    req_push = 0; req_force = 1;
    put(8'hFF, 0, 0, "R6");
    req_force = 0; req_push = 1;
    chk("R6", "holding register still full", hold_empty, 0);
    drain();
    chk("R6", "no extra frame after drop", exp_q.size(), 0);

    // R7: write on the very tick that transfers the queued character.
    put(8'h81, 0, 0, "R7");
    put(8'h42, 0, 0, "R7");
    req_race = 1; race_len = 10;
    put(8'h5A, 0, 0, "R7");
    req_race = 0;
    chk("R7", "raced write occupies holding register", hold_empty, 0);
    drain();

    // R9: break alone.
    req_brk = 1;
    do @(posedge clk); while (req_brk);
    @(negedge clk);
    chk("R9", "brk_pending set", brk_pending, 1);
    drain();
    chk("R9", "brk_pending cleared after break", brk_pending, 0);

    // R9: break beats waiting character.
    push_char(8'h11, 0, 0, "R9");
    push_brk();
    push_char(8'h22, 1, 1, "R9");
    req_push = 0;
    put(8'h11, 0, 0, "R9");
    put(8'h22, 1, 1, "R9");
    req_brk = 1;
    do @(posedge clk); while (req_brk);
    req_push = 1;
    drain();
    chk("R9", "brk_pending cleared after priority case", brk_pending, 0);

    // R10: disable mid-frame with a character queued.
    put(8'h99, 0, 0, "R10");
    put(8'h66, 0, 0, "R10");
    repeat (12) @(negedge clk);
    req_dis = 1;
    do @(posedge clk); while (req_dis);
    @(negedge clk);
    chk("R10", "line high after disable", tx_line, 1);
    chk("R10", "shift_empty after disable", shift_empty, 1);
    chk("R10", "hold_empty after disable", hold_empty, 1);
    req_push = 0; req_force = 1;
    put(8'h00, 0, 0, "R10");
    req_force = 0;
    req_brk = 1;
    repeat (50) @(negedge clk);
    req_push = 1;
    chk("R10", "write ignored while disabled", hold_empty, 1);
    chk("R10", "shifter idle while disabled", shift_empty, 1);
    chk("R10", "break ignored while disabled", brk_pending, 0);
    chk("R10", "line idle while disabled", tx_line, 1);

    // Re-enable and confirm normal operation resumes.
    tx_enable = 1'b1;
    put(8'h0F, 0, 0, "R2");
    drain();
    chk("R2", "all expected bits consumed", exp_q.size(), 0);
    finish_run();
  end

endmodule